// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Almost-Empty and Half-Full Flags

This block is an 18-bit-wide FIFO. Its write side and its read side run on independent clocks. The depth is a power of two set by a parameter, with a default of 1024. A master reset chooses the read timing mode:

- **Standard mode:** a word leaves only when it is requested.
- **Fall-through mode:** the oldest word is presented on the output before any request.

The same reset chooses one of two default almost-empty thresholds. Software can later replace the threshold through a load strobe on the read clock.

Three status outputs are provided, all active low:

- **Empty flag:** shows whether a word can be read.
- **Almost-empty flag:** low while the number of words held in storage is at or below the programmed offset n. It is computed on the read clock and passes through two register stages.
- **Half-full flag:** low while storage holds more than half the depth. It drops on the write edge that crosses half, and returns high on the read edge that brings the fill back to half or less.

In fall-through mode, the word already waiting in the output register is not counted toward either threshold. Both thresholds are therefore reached one write later than in standard mode.

Top module: `dcf_prog_fifo`

## Requirements
- R1: While rst_n is low on the clock edges, and after it is released with no writes, empty_n and ae_n are 0, half_n is 1 and rdata is 0.
- R2: On a reset edge, ld_sel=0 sets the offset n to 127 and ld_sel=1 sets it to 1023. Each value is clipped to depth-1 if it does not fit.
- R3: A read-clock edge with off_we=1 (not in reset) loads off_din into n. Any value from 0 to depth-1 is accepted.
- R4: ae_n is high exactly when the stored word count exceeds n. In standard mode with no reads, it goes high after n+1 writes.
- R5: In fall-through mode, the word waiting in the output register is excluded from the count. With no reads, ae_n goes high after n+2 writes.
- R6: ae_n follows the read-side count through two read-clock register stages. It never rises within one read-clock edge of the write that crosses the threshold.
- R7: half_n goes low on the write edge that makes the stored count exceed D/2. That is after D/2+1 writes in standard mode and D/2+2 in fall-through mode. It goes high on the read edge that brings the count to D/2 or less.
- R8: In standard mode, a read with empty_n=1 puts the oldest word on rdata at that read-clock edge. A read while empty_n=0 changes neither rdata nor the FIFO contents.
- R9: In fall-through mode, the first word written appears on rdata with empty_n=1 and no request. A read pops the held word and shows the next one. A read while empty_n=0 is ignored.
- R10: Writes made while the FIFO is full are dropped. Capacity is D words in standard mode and D+1 words in fall-through mode.
- R11: Words come out in the order they were written. Each pointer crossing between the clocks changes at most one Gray-code bit per edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wclk | input | 1 | Write clock |
| rclk | input | 1 | Read clock |
| rst_n | input | 1 | Master reset, active low, sampled on both clocks |
| fwft_sel | input | 1 | Mode select taken at reset: 1 = fall-through, 0 = standard |
| ld_sel | input | 1 | Default-offset select taken at reset: 0 = 127, 1 = 1023 |
| wen | input | 1 | Write request (write clock) |
| wdata | input | 18 | Write data |
| ren | input | 1 | Read request (read clock) |
| rdata | output | 18 | Read data / output register |
| off_we | input | 1 | Offset load strobe (read clock) |
| off_din | input | log2(DEPTH) | Offset value to load |
| empty_n | output | 1 | Empty flag, low when nothing can be read |
| ae_n | output | 1 | Almost-empty flag, low while count is at or below n |
| half_n | output | 1 | Half-full flag, low while count exceeds D/2 |

## Verification
The bench steps the fill one word at a time across every threshold, in both modes:

- **Almost-empty threshold:** writes n, then n+1, then n+2 words. A design that counted the fall-through word would raise ae_n one write early in fall-through mode.
- **Half-full threshold:** writes D/2 and then D/2+1 words. A design that set the flag from the read side would leave half_n high after the crossing write.
- **Offset register:** loads values of 0 and 5 through the port. A register that was not reloaded would keep the default threshold.
- **Flag latency:** checks ae_n one read edge after the crossing write. A missing stage would let it rise too soon.
- **Capacity:** overfills in both modes. Overwrites would surface as wrong or extra words during the drain.
- **Reads while empty:** issues reads in both modes while empty_n is low. A design that did not ignore them would corrupt rdata or lose the next word.

// File: rtl/dcf_pkg.sv
// Package: shared definitions for the dual-clock programmable-flag FIFO.
// Assumes: data width fixed at 18 bits for this product line.
package dcf_pkg;
    localparam int DCF_DATA_W = 18;
    localparam int DCF_OFF_LO = 127;
    localparam int DCF_OFF_HI = 1023;

    typedef enum logic {
        RD_STD  = 1'b0,
        RD_FWFT = 1'b1
    } rd_mode_e;
endpackage

// File: rtl/dcf_gray_sync.sv
// Module: two-flop synchroniser for a Gray-coded pointer, with binary decode.
// Assumes: gray_in changes by at most one bit per source edge.
module dcf_gray_sync #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] gray_in,
    output logic [W-1:0] bin_out
);
    logic [W-1:0] s1, s2;

    // Two register stages in the destination clock domain.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1 <= '0;
            s2 <= '0;
        end else begin
            s1 <= gray_in;
            s2 <= s1;
        end
    end

    // Gray to binary conversion of the synchronised value.
    always_comb begin
        bin_out[W-1] = s2[W-1];
        for (int i = W - 2; i >= 0; i--) begin
            bin_out[i] = bin_out[i+1] ^ s2[i];
        end
    end
endmodule

// File: rtl/dcf_mem.sv
// Module: storage array, written on the write clock, read combinationally.
// Assumes: the read side registers rdata itself.
module dcf_mem #(
    parameter int AW = 10,
    parameter int DW = 18
) (
    input  logic          wclk,
    input  logic          we,
    input  logic [AW-1:0] waddr,
    input  logic [DW-1:0] wdata,
    input  logic [AW-1:0] raddr,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] store [DEPTH];

    // Write port.
    always_ff @(posedge wclk) begin
        if (we) store[waddr] <= wdata;
    end

    assign rdata = store[raddr];
endmodule

// File: rtl/dcf_wr.sv
// Module: write-side pointer and full detection.
// Assumes: rbin_s is the read pointer already synchronised into wclk.
module dcf_wr #(
    parameter int AW = 10
) (
    input  logic        wclk,
    input  logic        rst_n,
    input  logic        wen,
    input  logic [AW:0] rbin_s,
    output logic [AW:0] wbin,
    output logic [AW:0] wgray,
    output logic        we_mem
);
    localparam logic [AW:0] DEPTH_P = {1'b1, {AW{1'b0}}};

    logic        full;
    logic [AW:0] wbin_nx;

    assign full    = (wbin - rbin_s) == DEPTH_P;
    assign we_mem  = wen & ~full;
    assign wbin_nx = wbin + 1'b1;

    // Advance the binary and Gray write pointers on an accepted write.
    always_ff @(posedge wclk) begin
        if (!rst_n) begin
            wbin  <= '0;
            wgray <= '0;
        end else if (we_mem) begin
            wbin  <= wbin_nx;
            wgray <= wbin_nx ^ (wbin_nx >> 1);
        end
    end

    p_full_drop_r10: assert property (@(posedge wclk) disable iff (!rst_n)
        (wen && full) |=> (wbin == $past(wbin)));

    p_wgray_step_r11: assert property (@(posedge wclk) disable iff (!rst_n)
        $countones(wgray ^ $past(wgray)) <= 1);
endmodule

// File: rtl/dcf_rd.sv
// Module: read-side pointer, mode and offset registers, output register,
//         empty flag and double-registered almost-empty flag.
// Assumes: wbin_s is the write pointer synchronised into rclk; mem_rdata
//          is the combinational word at address rbin.
module dcf_rd
    import dcf_pkg::*;
#(
    parameter int AW     = 10,
    parameter int DW     = 18,
    parameter int OFF_LO = 127,
    parameter int OFF_HI = 1023
) (
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          fwft_sel,
    input  logic          ld_sel,
    input  logic          off_we,
    input  logic [AW-1:0] off_din,
    input  logic          ren,
    input  logic [AW:0]   wbin_s,
    input  logic [DW-1:0] mem_rdata,
    output logic [AW:0]   rbin,
    output logic [AW:0]   rgray,
    output logic [DW-1:0] dout,
    output logic          empty_n,
    output logic          ae_n
);
    localparam logic [AW:0] DEPTH_P = {1'b1, {AW{1'b0}}};

    rd_mode_e      mode;
    logic [AW-1:0] off;
    logic          held;
    logic [AW:0]   cnt;
    logic          mem_empty;
    logic          take;
    logic [AW:0]   rbin_nx;
    logic          ae_s1;

    assign cnt       = wbin_s - rbin;
    assign mem_empty = (cnt == '0);
    assign rbin_nx   = rbin + 1'b1;
    assign take      = (mode == RD_FWFT) ? (~mem_empty & (~held | ren))
                                         : (ren & ~mem_empty);
    assign empty_n   = (mode == RD_FWFT) ? held : ~mem_empty;

    // Latch mode and default offset at reset; reload offset on strobe.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            mode <= fwft_sel ? RD_FWFT : RD_STD;
            off  <= ld_sel ? AW'(OFF_HI) : AW'(OFF_LO);
        end else if (off_we) begin
            off <= off_din;
        end
    end

    // Pop from storage into the output register and track the held word.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            rbin  <= '0;
            rgray <= '0;
            dout  <= '0;
            held  <= 1'b0;
        end else begin
            if (take) begin
                dout  <= mem_rdata;
                rbin  <= rbin_nx;
                rgray <= rbin_nx ^ (rbin_nx >> 1);
            end
            held <= (mode == RD_FWFT) & (take | (held & ~ren));
        end
    end

    // Two register stages for the almost-empty flag.
    always_ff @(posedge rclk) begin
        if (!rst_n) begin
            ae_s1 <= 1'b0;
            ae_n  <= 1'b0;
        end else begin
            ae_s1 <= (cnt > {1'b0, off});
            ae_n  <= ae_s1;
        end
    end

    p_reset_state_r1: assert property (@(posedge rclk)
        !rst_n |=> (!empty_n && !ae_n && dout == '0));

    p_std_empty_read_r8: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode == RD_STD && ren && mem_empty) |=> ($stable(rbin) && $stable(dout)));

    p_fwft_hold_r9: assert property (@(posedge rclk) disable iff (!rst_n)
        (mode == RD_FWFT && empty_n && !ren) |=> (empty_n && $stable(dout)));

    p_count_bound_r10: assert property (@(posedge rclk) disable iff (!rst_n)
        cnt <= DEPTH_P);

    p_rgray_step_r11: assert property (@(posedge rclk) disable iff (!rst_n)
        $countones(rgray ^ $past(rgray)) <= 1);
endmodule

// File: rtl/dcf_prog_fifo.sv
// Module: top of the dual-clock FIFO with programmable flags.
// Assumes: DEPTH is a power of two; rst_n is held low for at least two
//          edges of each clock; off_we/off_din are in the rclk domain.
module dcf_prog_fifo
    import dcf_pkg::*;
#(
    parameter int DEPTH = 1024,
    parameter int DW    = DCF_DATA_W,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          wclk,
    input  logic          rclk,
    input  logic          rst_n,
    input  logic          fwft_sel,
    input  logic          ld_sel,
    input  logic          wen,
    input  logic [DW-1:0] wdata,
    input  logic          ren,
    output logic [DW-1:0] rdata,
    input  logic          off_we,
    input  logic [AW-1:0] off_din,
    output logic          empty_n,
    output logic          ae_n,
    output logic          half_n
);
    localparam int          OFF_LO = (DCF_OFF_LO < DEPTH - 1) ? DCF_OFF_LO : DEPTH - 1;
    localparam int          OFF_HI = (DCF_OFF_HI < DEPTH - 1) ? DCF_OFF_HI : DEPTH - 1;
    localparam logic [AW:0] HALF_P = {2'b01, {(AW - 1){1'b0}}};

    logic [AW:0]   wbin, wgray, rbin, rgray, rbin_s, wbin_s;
    logic          we_mem;
    logic [DW-1:0] mem_q;
    logic [AW:0]   fill_x;

    dcf_gray_sync #(.W(AW + 1)) u_r2w (
        .clk(wclk), .rst_n(rst_n), .gray_in(rgray), .bin_out(rbin_s)
    );

    dcf_gray_sync #(.W(AW + 1)) u_w2r (
        .clk(rclk), .rst_n(rst_n), .gray_in(wgray), .bin_out(wbin_s)
    );

    dcf_wr #(.AW(AW)) u_wr (
        .wclk(wclk), .rst_n(rst_n), .wen(wen), .rbin_s(rbin_s),
        .wbin(wbin), .wgray(wgray), .we_mem(we_mem)
    );

    dcf_mem #(.AW(AW), .DW(DW)) u_mem (
        .wclk(wclk), .we(we_mem), .waddr(wbin[AW-1:0]), .wdata(wdata),
        .raddr(rbin[AW-1:0]), .rdata(mem_q)
    );

    dcf_rd #(.AW(AW), .DW(DW), .OFF_LO(OFF_LO), .OFF_HI(OFF_HI)) u_rd (
        .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel), .ld_sel(ld_sel),
        .off_we(off_we), .off_din(off_din), .ren(ren), .wbin_s(wbin_s),
        .mem_rdata(mem_q), .rbin(rbin), .rgray(rgray), .dout(rdata),
        .empty_n(empty_n), .ae_n(ae_n)
    );

    // Half-full: compare the live pointers of both domains, so the flag
    // moves on the write edge that crosses half and on the read edge back.
    assign fill_x = wbin - rbin;
    assign half_n = ~(fill_x > HALF_P);

    p_half_reset_r7: assert property (@(posedge wclk)
        !rst_n |=> half_n);
endmodule

// File: tb/tb_dcf_prog_fifo.sv
module tb_dcf_prog_fifo;
    localparam int D  = 1024;
    localparam int AW = 10;
    localparam int DW = 18;

    logic          wclk = 1'b0, rclk = 1'b0;
    logic          rst_n = 1'b0, fwft_sel = 1'b0, ld_sel = 1'b0;
    logic          wen = 1'b0, ren = 1'b0, off_we = 1'b0;
    logic [DW-1:0] wdata = '0;
    logic [AW-1:0] off_din = '0;
    logic [DW-1:0] rdata;
    logic          empty_n, ae_n, half_n;

    int n_cmp = 0, n_bad = 0;
    int wr_idx = 0;
    logic [DW-1:0] q[$];
    bit fwft_m = 1'b0;

    always #10 wclk = ~wclk;
    always #13 rclk = ~rclk;

    dcf_prog_fifo #(.DEPTH(D)) dut (
        .wclk(wclk), .rclk(rclk), .rst_n(rst_n), .fwft_sel(fwft_sel),
        .ld_sel(ld_sel), .wen(wen), .wdata(wdata), .ren(ren), .rdata(rdata),
        .off_we(off_we), .off_din(off_din), .empty_n(empty_n), .ae_n(ae_n),
        .half_n(half_n)
    );

    function automatic logic [DW-1:0] gen(int i);
        return DW'((i * 37 + 5) ^ (i << 7));
    endfunction

    // Expected almost-empty level from the stored (non-held) count.
    function automatic logic exp_ae(int cnt, int n);
        return cnt > n;
    endfunction

    function automatic logic exp_half(int cnt);
        return !(cnt > D / 2);
    endfunction

    function automatic int cap();
        return fwft_m ? D + 1 : D;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic do_reset(bit fw, bit ld);
        @(negedge wclk);
        rst_n = 1'b0; fwft_sel = fw; ld_sel = ld;
        repeat (3) @(negedge rclk);
        repeat (3) @(negedge wclk);
        rst_n = 1'b1;
        fwft_m = fw;
        q.delete();
    endtask

    task automatic settle();
        repeat (6) @(negedge rclk);
        repeat (6) @(negedge wclk);
    endtask

    task automatic write_one(logic [DW-1:0] d);
        @(negedge wclk);
        wen = 1'b1; wdata = d;
        @(negedge wclk);
        wen = 1'b0;
        if (q.size() < cap()) q.push_back(d);
    endtask

    task automatic write_seq(int n);
        for (int i = 0; i < n; i++) begin
            write_one(gen(wr_idx));
            wr_idx++;
        end
    endtask

    task automatic pulse_ren();
        @(negedge rclk);
        ren = 1'b1;
        @(negedge rclk);
        ren = 1'b0;
    endtask

    // Standard read: data appears at the edge of the request.
    task automatic read_std(string req);
        logic [DW-1:0] e;
        pulse_ren();
        e = q.pop_front();
        check(req, rdata, e);
    endtask

    // Fall-through read: check the held word, then pop it.
    task automatic read_fwft(string req);
        logic [DW-1:0] e;
        e = q.pop_front();
        check(req, rdata, e);
        pulse_ren();
    endtask

    task automatic load_off(int v);
        @(negedge rclk);
        off_we = 1'b1; off_din = AW'(v);
        @(negedge rclk);
        off_we = 1'b0;
    endtask

    initial begin
        logic [DW-1:0] keep;
        void'($urandom(32'd20240611));

        // Standard mode, low default offset.
        do_reset(1'b0, 1'b0);
        @(negedge rclk);
        check("R1 empty_n", empty_n, 0);
        check("R1 ae_n", ae_n, 0);
        check("R1 half_n", half_n, 1);
        check("R1 rdata", rdata, 0);

        write_seq(127);
        settle();
        check("R4/R2 127 writes ae_n", ae_n, exp_ae(q.size(), 127));
        check("R8 empty_n with data", empty_n, 1);
        write_seq(1);
        @(negedge rclk);
        check("R6 ae_n latency", ae_n, 0);
        settle();
        check("R4/R2 128 writes ae_n", ae_n, exp_ae(q.size(), 127));

        write_seq(384);
        check("R7 512 stored half_n", half_n, exp_half(q.size()));
        write_seq(1);
        check("R7 513 stored half_n", half_n, exp_half(q.size()));
        read_std("R8 first word");
        check("R7 read back to 512 half_n", half_n, exp_half(q.size()));

        write_seq(512);
        for (int i = 0; i < 3; i++) write_one(18'h3ABCD);
        settle();
        check("R10 count at capacity", q.size(), D);
        while (q.size() > 0) read_std("R11/R10 drain order");
        keep = rdata;
        @(negedge rclk);
        check("R8 empty after drain", empty_n, 0);
        pulse_ren();
        check("R8 read while empty ignored", rdata, keep);
        settle();
        check("R4 ae_n low when drained", ae_n, 0);
        check("R7 half_n high when drained", half_n, 1);

        // Offset loading through the port.
        load_off(5);
        write_seq(5);
        settle();
        check("R3 offset 5, 5 words", ae_n, exp_ae(q.size(), 5));
        write_seq(1);
        settle();
        check("R3 offset 5, 6 words", ae_n, exp_ae(q.size(), 5));
        while (q.size() > 0) read_std("R8 drain after offset 5");
        load_off(0);
        settle();
        check("R3 offset 0, empty", ae_n, 0);
        write_seq(1);
        settle();
        check("R3 offset 0, 1 word", ae_n, exp_ae(q.size(), 0));
        read_std("R8 drain after offset 0");

        // Fall-through mode, high default offset.
        do_reset(1'b1, 1'b1);
        @(negedge rclk);
        check("R1 fwft empty_n", empty_n, 0);
        check("R1 fwft ae_n", ae_n, 0);
        pulse_ren();
        write_seq(1);
        settle();
        check("R9 word falls through", empty_n, 1);
        check("R9 first word without request", rdata, q[0]);
        write_seq(512);
        check("R7 fwft 513 writes half_n", half_n, 1);
        write_seq(1);
        check("R7 fwft 514 writes half_n", half_n, 0);
        write_seq(510);
        settle();
        check("R5/R2 fwft 1024 writes ae_n", ae_n, exp_ae(q.size() - 1, 1023));
        write_seq(1);
        settle();
        check("R5/R2 fwft 1025 writes ae_n", ae_n, exp_ae(q.size() - 1, 1023));
        write_one(18'h15555);
        write_one(18'h2AAAA);
        settle();
        check("R10 fwft capacity", q.size(), D + 1);
        while (q.size() > 0) read_fwft("R9/R11 fwft drain order");
        @(negedge rclk);
        check("R9 fwft empty after drain", empty_n, 0);
        pulse_ren();
        write_seq(1);
        settle();
        check("R9 read while empty ignored", rdata, q[0]);
        read_fwft("R9 pop after ignored read");

        // Random mixed traffic in standard mode.
        do_reset(1'b0, 1'b0);
        for (int op = 0; op < 3000; op++) begin
            int r;
            r = int'($urandom % 3);
            if (r != 0) begin
                if (q.size() < D - 16) begin
                    write_one(DW'($urandom));
                end
            end else begin
                @(negedge rclk);
                if (empty_n) read_std("R8/R11 random read");
            end
            if (op % 250 == 249) begin
                settle();
                check("R4 random ae_n", ae_n, exp_ae(q.size(), 127));
                check("R7 random half_n", half_n, exp_half(q.size()));
            end
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        #(200000 * 20);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog actual=running expected=done");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule